// File: doc/BRIEF.md
# Cipher Engine Register Front-End and Stream Sequencer

This block sits between a 32-bit register bus and a 128-bit block cipher core. Software programs a mode word and a control word, raises the start bit, then feeds one input data register with a stream of 32-bit words. The block splits that stream into a header and a payload. The header holds an optional block count, an optional four-word key and an optional four-word initial vector. The payload follows in 128-bit blocks of four words. Each assembled block goes to the cipher core over a valid/ready handshake. The core's answer is split back into words and queued for software to read from the output data register.

The header layout depends on the mode word. A count word is present unless the count is marked undefined. Key words are present unless the stored key is reused. Vector words are present in every chaining mode except ECB. When a defined count has been served, the block can append the stored key to the output as a trailer, and it then flags completion. Three sticky cause bits (completion, input overflow, output underflow) drive a single interrupt line through an enable bit. A programmable divider produces the core clock-enable.

Top module: `cipher_stream_ctrl`

## Requirements
- R1: Byte offsets are control/status 0x00, input data 0x04, output data 0x08, cause 0x0C, mode 0x10. After reset the control, cause and mode registers read 0, `irq` is low, and control/status reads 0x20 because the input queue has space.
- R2: Control bits are bit0 start, bit1 interrupt enable and bits[3:2] ratio r. `core_ce` pulses once every 2^r clock cycles: 00 gives every cycle, 01 every 2, 10 every 4, 11 every 8. Read-only bit4 is 1 while the output queue holds data. Read-only bit5 is 1 while the input queue is not full.
- R3: Mode bits are bit0 decrypt, bit1 internal key generation, bit2 key replay, bit3 reuse stored key, bit4 count undefined, and bits[6:5] chaining (00 ECB, 01 CBC, 10 CFB, 11 OFB). After start the stream carries, in this order: the count word if bit4=0, then four key words if bit3=0, then four vector words if the mode is not ECB. Header words are big-endian, so the first word lands in `core_key[127:96]` or `core_iv[127:96]`.
- R4: Payload is four words per block. The first word goes to `core_block[127:96]`. Results are returned in the same word order, and blocks leave in arrival order.
- R5: With a defined count N, completion (cause bit0) sets once N blocks and any trailer have been queued. N=0 completes right after the header. With an undefined count, completion never sets.
- R6: In ECB with a defined count and either decrypt or key replay set, four stored-key words follow the last result, first word = key[127:96]. Otherwise no trailer is queued.
- R7: A write to input data while the 8-word input queue is full is dropped and sets cause bit1.
- R8: A read of output data while the output queue is empty returns 0 and sets cause bit2.
- R9: A write to the cause register keeps only the bits written as 1, so writing 0 clears all causes.
- R10: `irq` is high exactly when interrupt enable is set and at least one cause bit is set.
- R11: Clearing the start bit aborts the run, empties both queues and returns the sequencer to idle. The stored key survives, and a later reuse-key run uses it.
- R12: `core_valid` and `core_block` stay stable until `core_ready`. A block is offered only when the 8-word output queue has room for its four result words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops output data at 0x08) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Interrupt request |
| core_ce | output | 1 | Divided clock-enable for the core |
| core_valid | output | 1 | Block offered to the core |
| core_ready | input | 1 | Core accepts the offered block |
| core_block | output | 128 | Payload block |
| core_key | output | 128 | Stored key |
| core_iv | output | 128 | Stored initial vector |
| core_first | output | 1 | Offered block is the first of the run |
| core_decrypt | output | 1 | Decrypt selected |
| core_keygen | output | 1 | Internal key generation requested |
| core_mode | output | 2 | Chaining mode |
| rsp_valid | input | 1 | Core result valid, one cycle |
| rsp_block | input | 128 | Core result block |

## Verification
The assertions rely on these conditions: the mode word does not change while start is set; the bus never writes and reads in the same cycle; and the core raises `rsp_valid` exactly once for each block it accepts. The bench keeps to them. It changes the mode only between runs. Its bus tasks issue one access at a time. Its stub core answers only after a handshake, after a random delay of zero to three cycles. Every run drains all outstanding results before the start bit is cleared.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 128;
  localparam int WPB    = BLK_W / WORD_W;

  typedef struct packed {
    logic [1:0] chain;   // 00 ECB
    logic       undef;
    logic       reuse;
    logic       replay;
    logic       keygen;
    logic       decrypt;
  } mode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CNT, S_KEY, S_IV, S_LOAD, S_ISSUE, S_WAIT, S_PUSH, S_TRAIL, S_DONE
  } seq_st_t;

  function automatic seq_st_t after_key(mode_t m);
    return (m.chain == 2'b00) ? S_LOAD : S_IV;
  endfunction

  function automatic seq_st_t after_cnt(mode_t m);
    return m.reuse ? after_key(m) : S_KEY;
  endfunction

  function automatic logic trailer_on(mode_t m);
    return (m.chain == 2'b00) && !m.undef && (m.decrypt || m.replay);
  endfunction

  function automatic logic [2:0] ratio_mask(logic [1:0] r);
    logic [3:0] t;
    t = 4'd1 << r;
    return 3'(t - 4'd1);
  endfunction
endpackage

// File: rtl/csc_word_fifo.sv
module csc_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic [AW:0]  count
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wdata;
        wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R12
endmodule

// File: rtl/csc_rate_div.sv
module csc_rate_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio,
  output logic       ce
);
  import csc_pkg::*;
  logic [2:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 3'd1;
  end
  assign ce = ((cnt & ratio_mask(ratio)) == 3'd0);
endmodule

// File: rtl/csc_sequencer.sv
module csc_sequencer
  import csc_pkg::*;
#(
  parameter int OUT_DEPTH = 8,
  parameter int CNT_W     = 16,
  localparam int OCW      = $clog2(OUT_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  mode_t             mode,
  input  logic              in_empty,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_pop,
  input  logic [OCW-1:0]    out_count,
  input  logic              out_full,
  output logic              out_push,
  output logic [WORD_W-1:0] out_word,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [BLK_W-1:0]  core_block,
  output logic [BLK_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_iv,
  output logic              core_first,
  input  logic              rsp_valid,
  input  logic [BLK_W-1:0]  rsp_block,
  output logic              done_evt
);
  seq_st_t st, nxt;
  logic [1:0]       widx;
  logic [CNT_W-1:0] cnt_q, done_q;
  logic [BLK_W-1:0] res_q;
  logic             finished, room, last_w;

  assign finished   = !mode.undef && (done_q == cnt_q);
  assign room       = (int'(out_count) <= OUT_DEPTH - WPB);
  assign last_w     = (widx == 2'(WPB-1));
  assign core_valid = (st == S_ISSUE) && room;

  always_comb begin
    nxt = st; in_pop = 1'b0; out_push = 1'b0; out_word = '0; done_evt = 1'b0;
    case (st)
      S_IDLE:  if (go) nxt = mode.undef ? after_cnt(mode) : S_CNT;
      S_CNT:   if (!in_empty) begin in_pop = 1'b1; nxt = after_cnt(mode); end
      S_KEY:   if (!in_empty) begin in_pop = 1'b1; if (last_w) nxt = after_key(mode); end
      S_IV:    if (!in_empty) begin in_pop = 1'b1; if (last_w) nxt = S_LOAD; end
      S_LOAD:
        if (finished) begin
          nxt = trailer_on(mode) ? S_TRAIL : S_DONE;
          done_evt = !trailer_on(mode);
        end else if (!in_empty) begin
          in_pop = 1'b1; if (last_w) nxt = S_ISSUE;
        end
      S_ISSUE: if (core_valid && core_ready) nxt = S_WAIT;
      S_WAIT:  if (rsp_valid) nxt = S_PUSH;
      S_PUSH: begin
        out_push = 1'b1;
        out_word = res_q[(WPB-1-int'(widx))*WORD_W +: WORD_W];
        if (last_w) nxt = S_LOAD;
      end
      S_TRAIL:
        if (!out_full) begin
          out_push = 1'b1;
          out_word = core_key[(WPB-1-int'(widx))*WORD_W +: WORD_W];
          if (last_w) begin nxt = S_DONE; done_evt = 1'b1; end
        end
      default: ;
    endcase
    if (abort) begin
      nxt = S_IDLE; in_pop = 1'b0; out_push = 1'b0; done_evt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; cnt_q <= '0; done_q <= '0; res_q <= '0;
      core_key <= '0; core_iv <= '0; core_block <= '0; core_first <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)                widx <= '0;
      else if (in_pop || out_push)  widx <= widx + 2'd1;
      if (go) begin done_q <= '0; core_first <= 1'b1; end
      if (in_pop) begin
        case (st)
          S_CNT:  cnt_q <= in_word[CNT_W-1:0];
          S_KEY:  core_key[(WPB-1-int'(widx))*WORD_W +: WORD_W] <= in_word;
          S_IV:   core_iv[(WPB-1-int'(widx))*WORD_W +: WORD_W] <= in_word;
          default: core_block[(WPB-1-int'(widx))*WORD_W +: WORD_W] <= in_word;
        endcase
      end
      if (core_valid && core_ready) core_first <= 1'b0;
      if (st == S_WAIT && rsp_valid) res_q <= rsp_block;
      if (st == S_PUSH && last_w && !abort) done_q <= done_q + 1'b1;
    end
  end

  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && !core_ready && !abort) |=> (core_valid && $stable(core_block))); // R12
  AST_DONE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !mode.undef); // R5
endmodule

// File: rtl/cipher_stream_ctrl.sv
module cipher_stream_ctrl
  import csc_pkg::*;
#(
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 8,
  parameter int CNT_W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [4:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         irq,
  output logic         core_ce,
  output logic         core_valid,
  input  logic         core_ready,
  output logic [127:0] core_block,
  output logic [127:0] core_key,
  output logic [127:0] core_iv,
  output logic         core_first,
  output logic         core_decrypt,
  output logic         core_keygen,
  output logic [1:0]   core_mode,
  input  logic         rsp_valid,
  input  logic [127:0] rsp_block
);
  localparam int IAW = $clog2(IN_DEPTH) + 1;
  localparam int OAW = $clog2(OUT_DEPTH) + 1;
  localparam logic [2:0] A_CTL = 3'd0, A_IN = 3'd1, A_OUT = 3'd2, A_CAUSE = 3'd3, A_MODE = 3'd4;

  logic       start_q, ie_q;
  logic [1:0] ratio_q;
  mode_t      mode_q;
  logic [2:0] cause_q;
  logic [2:0] reg_sel;

  logic go, abort, in_push, ovf_evt, out_pop, unf_evt, done_evt;
  logic in_pop, in_full, in_empty, out_push, out_full, out_empty;
  logic [31:0] in_word, out_word, out_head;
  logic [IAW-1:0] in_count;
  logic [OAW-1:0] out_count;

  assign reg_sel = bus_addr[4:2];
  assign go      = bus_wr && reg_sel == A_CTL && !start_q && bus_wdata[0];
  assign abort   = bus_wr && reg_sel == A_CTL && start_q && !bus_wdata[0];
  assign in_push = bus_wr && reg_sel == A_IN && !in_full;
  assign ovf_evt = bus_wr && reg_sel == A_IN && in_full;
  assign out_pop = bus_rd && reg_sel == A_OUT && !out_empty;
  assign unf_evt = bus_rd && reg_sel == A_OUT && out_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0; ie_q <= 1'b0; ratio_q <= '0; mode_q <= '0; cause_q <= '0;
    end else begin
      if (bus_wr && reg_sel == A_CTL) {ratio_q, ie_q, start_q} <= bus_wdata[3:0];
      if (bus_wr && reg_sel == A_MODE) mode_q <= mode_t'(bus_wdata[6:0]);
      cause_q <= ((bus_wr && reg_sel == A_CAUSE) ? (cause_q & bus_wdata[2:0]) : cause_q)
                 | {unf_evt, ovf_evt, done_evt};
    end
  end

  assign irq          = ie_q && (cause_q != 3'b000);
  assign core_decrypt = mode_q.decrypt;
  assign core_keygen  = mode_q.keygen;
  assign core_mode    = mode_q.chain;

  always_comb begin
    case (reg_sel)
      A_CTL:   bus_rdata = {26'd0, !in_full, !out_empty, ratio_q, ie_q, start_q};
      A_OUT:   bus_rdata = out_empty ? 32'd0 : out_head;
      A_CAUSE: bus_rdata = {29'd0, cause_q};
      A_MODE:  bus_rdata = {25'd0, mode_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  csc_word_fifo #(.W(32), .DEPTH(IN_DEPTH)) u_in (
    .clk(clk), .rst_n(rst_n), .flush(abort), .push(in_push), .wdata(bus_wdata),
    .pop(in_pop), .rdata(in_word), .full(in_full), .empty(in_empty), .count(in_count));

  csc_word_fifo #(.W(32), .DEPTH(OUT_DEPTH)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(abort), .push(out_push), .wdata(out_word),
    .pop(out_pop), .rdata(out_head), .full(out_full), .empty(out_empty), .count(out_count));

  csc_rate_div u_div (.clk(clk), .rst_n(rst_n), .ratio(ratio_q), .ce(core_ce));

  csc_sequencer #(.OUT_DEPTH(OUT_DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .mode(mode_q),
    .in_empty(in_empty), .in_word(in_word), .in_pop(in_pop),
    .out_count(out_count), .out_full(out_full), .out_push(out_push), .out_word(out_word),
    .core_valid(core_valid), .core_ready(core_ready), .core_block(core_block),
    .core_key(core_key), .core_iv(core_iv), .core_first(core_first),
    .rsp_valid(rsp_valid), .rsp_block(rsp_block), .done_evt(done_evt));

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reg_sel == A_OUT && out_empty) |-> (bus_rdata == 32'd0)); // R8
  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (in_empty && out_empty)); // R11
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_sel == A_IN && in_count == IAW'(IN_DEPTH)) |=> cause_q[1]); // R7
endmodule

// File: tb/cipher_stream_ctrl_test.sv
module cipher_stream_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, core_ce, core_valid, core_ready, core_first, core_decrypt, core_keygen;
  logic [1:0] core_mode;
  logic [127:0] core_block, core_key, core_iv, rsp_block, res;
  logic rsp_valid, pend, stub_hold;
  int lat, accepts, ce_cnt, checks, fails;
  bit finished;

  always #10 clk = ~clk;

  cipher_stream_ctrl uut (.*);

  assign core_ready = !stub_hold && !pend;
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (core_ce) ce_cnt <= ce_cnt + 1;
    if (!rst_n) begin pend <= 1'b0; accepts <= 0; rsp_block <= '0; end
    else if (pend) begin
      if (lat == 0) begin rsp_valid <= 1'b1; rsp_block <= res; pend <= 1'b0; end
      else lat <= lat - 1;
    end else if (core_valid && core_ready) begin
      pend <= 1'b1; lat <= $urandom_range(0, 3); res <= core_block ^ core_key;
      accepts <= accepts + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #5; d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic put(input logic [31:0] d);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin rd(5'h00, s); if (s[5]) break; end
    wr(5'h04, d);
  endtask

  task automatic get(output logic [31:0] d);
    logic [31:0] s;
    for (int i = 0; i < 200; i++) begin rd(5'h00, s); if (s[4]) break; end
    rd(5'h08, d);
  endtask

  task automatic wait_done(output logic [31:0] c);
    for (int i = 0; i < 100; i++) begin rd(5'h0C, c); if (c[0]) break; end
  endtask

  function automatic logic [31:0] mk_mode(int ch, bit und, bit reu, bit rep, bit dec);
    return {25'd0, 2'(ch), und, reu, rep, 1'b0, dec};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, c, w, kw[4], iv[4], d[4];
    int n, a0, c0;
    void'($urandom(32'h5eed));
    stub_hold = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    rd(5'h00, s); chk(s == 32'h20, "R1 ctl", s, 32'h20);
    rd(5'h0C, s); chk(s == 0, "R1 cause", s, 0);
    rd(5'h10, s); chk(s == 0, "R1 mode", s, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    // R2 ratio
    for (int r = 0; r < 4; r++) begin
      wr(5'h00, 32'(r << 2));
      c0 = ce_cnt; repeat (32) @(posedge clk); #1;
      chk(ce_cnt - c0 == (32 >> r), "R2 ratio", ce_cnt - c0, 32 >> r);
    end
    wr(5'h00, 0);
    for (int i = 0; i < 4; i++) kw[i] = 0;
    // R3 R4 R5 R6 R10 random runs
    for (int run = 0; run < 8; run++) begin
      int ch, nb; bit dec, reu, rep;
      ch = $urandom % 4; dec = 1'($urandom); rep = 1'($urandom);
      reu = (run > 0) && 1'($urandom); nb = 1 + $urandom % 4;
      if (run == 1) begin ch = 0; dec = 1; end
      if (run == 2) begin ch = 0; dec = 0; rep = 0; end
      if (!reu) for (int i = 0; i < 4; i++) kw[i] = $urandom;
      for (int i = 0; i < 4; i++) iv[i] = $urandom;
      wr(5'h10, mk_mode(ch, 0, reu, rep, dec));
      wr(5'h00, 32'h3);
      put(32'(nb));
      if (!reu) for (int i = 0; i < 4; i++) put(kw[i]);
      if (ch != 0) for (int i = 0; i < 4; i++) put(iv[i]);
      for (int b = 0; b < nb; b++) begin
        for (int i = 0; i < 4; i++) begin d[i] = $urandom; put(d[i]); end
        for (int i = 0; i < 4; i++) begin
          get(w); chk(w == (d[i] ^ kw[i]), "R4 result word", w, d[i] ^ kw[i]);
        end
      end
      if (ch == 0 && (dec || rep)) begin
        for (int i = 0; i < 4; i++) begin get(w); chk(w == kw[i], "R6 trailer", w, kw[i]); end
      end
      wait_done(c);
      rd(5'h00, s); chk(s[4] == 1'b0, "R6 no extra words", s[4], 0);
      chk(c == 32'h1, "R5 completion", c, 1);
      chk(irq == 1'b1, "R10 irq set", irq, 1);
      chk(core_key == {kw[0], kw[1], kw[2], kw[3]}, "R3 key", core_key, {kw[0], kw[1], kw[2], kw[3]});
      if (ch != 0) chk(core_iv == {iv[0], iv[1], iv[2], iv[3]}, "R3 iv", core_iv, {iv[0], iv[1], iv[2], iv[3]});
      wr(5'h00, 0);
      chk(irq == 1'b0, "R10 irq masked", irq, 0);
      wr(5'h0C, 0);
    end
    // R5 zero count
    wr(5'h10, mk_mode(0, 0, 1, 0, 0)); wr(5'h00, 32'h1); put(0);
    repeat (6) @(posedge clk);
    rd(5'h0C, c); chk(c == 1, "R5 zero count", c, 1);
    rd(5'h00, s); chk(s[4] == 0, "R5 zero count no data", s[4], 0);
    wr(5'h00, 0); wr(5'h0C, 0);
    // R12 output room: undefined count, three blocks, no reads
    wr(5'h10, mk_mode(0, 1, 1, 0, 0)); wr(5'h00, 32'h1);
    a0 = accepts;
    for (int i = 0; i < 12; i++) put(32'h100 + i);
    repeat (40) @(posedge clk); #1;
    chk(accepts - a0 == 2, "R12 room gate", accepts - a0, 2);
    chk(core_valid == 0, "R12 valid low when full", core_valid, 0);
    for (int i = 0; i < 12; i++) begin
      get(w); chk(w == ((32'h100 + i) ^ kw[i % 4]), "R12 data order", w, (32'h100 + i) ^ kw[i % 4]);
    end
    rd(5'h0C, c); chk(c[0] == 0, "R5 undefined never done", c[0], 0);
    wr(5'h00, 0);
    // R7 overflow and R12 hold
    stub_hold = 1'b1;
    wr(5'h00, 32'h1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(5'h00, s); if (!s[5]) break;
      wr(5'h04, 32'h200 + n); n++;
    end
    chk(n == 12, "R7 accepted words", n, 12);
    chk(core_valid && core_block == {32'h200, 32'h201, 32'h202, 32'h203}, "R12 hold",
        core_block, {32'h200, 32'h201, 32'h202, 32'h203});
    wr(5'h04, 32'hdead);
    rd(5'h0C, c); chk(c == 32'h2, "R7 overflow cause", c, 2);
    stub_hold = 1'b0;
    for (int i = 0; i < 12; i++) begin
      get(w); chk(w == ((32'h200 + i) ^ kw[i % 4]), "R7 kept words", w, (32'h200 + i) ^ kw[i % 4]);
    end
    for (int i = 0; i < 3; i++) put(32'h300 + i);
    repeat (20) @(posedge clk);
    rd(5'h00, s); chk(s[4] == 0, "R7 dropped word absent", s[4], 0);
    wr(5'h00, 0); wr(5'h0C, 0);
    // R8 R9 R10
    rd(5'h08, w); chk(w == 0, "R8 empty read", w, 0);
    rd(5'h0C, c); chk(c == 32'h4, "R8 underflow cause", c, 4);
    chk(irq == 0, "R10 no enable", irq, 0);
    wr(5'h00, 32'h2); #1; chk(irq == 1, "R10 enable", irq, 1);
    wr(5'h00, 0);
    wr(5'h0C, 32'h4); rd(5'h0C, c); chk(c == 32'h4, "R9 keep ones", c, 4);
    wr(5'h0C, 32'h3); rd(5'h0C, c); chk(c == 0, "R9 clear", c, 0);
    // R11 abort keeps key
    wr(5'h10, mk_mode(0, 0, 0, 0, 0)); wr(5'h00, 32'h1);
    put(1); put(32'h1111_1111); put(32'h2222_2222);
    wr(5'h00, 0);
    rd(5'h00, s); chk(s[5:4] == 2'b10, "R11 flushed", s[5:4], 2'b10);
    chk(core_key[63:0] == {kw[2], kw[3]}, "R11 key tail kept", core_key[63:0], {kw[2], kw[3]});
    wr(5'h10, mk_mode(0, 0, 1, 0, 0)); wr(5'h00, 32'h1);
    put(1); for (int i = 0; i < 4; i++) put(32'h400 + i);
    for (int i = 0; i < 4; i++) begin
      get(w); chk(w == ((32'h400 + i) ^ (i < 2 ? (i == 0 ? 32'h1111_1111 : 32'h2222_2222) : kw[i])),
                  "R11 reuse after abort", w, (32'h400 + i) ^ (i < 2 ? (i == 0 ? 32'h1111_1111 : 32'h2222_2222) : kw[i]));
    end
    wait_done(c); chk(c == 1, "R11 run completes", c, 1);
    wr(5'h00, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule